// File: doc/BRIEF.md
# Multiplexed Byte Bus Controller

This block sits between a 16-bit processor core and an 8-bit multiplexed address/data bus. The core issues one request at a time: read or write, byte or word, and for reads whether it is an instruction fetch. An external access runs as a sequence of byte cycles. Each byte cycle has an address phase, a strobe phase, optional wait states, a data phase and an end phase. A word is split into two byte cycles, low byte first. The controller raises a completion pulse when the last byte is finished.

The address strobe pin works in one of two modes, chosen by a configuration input. In pulse mode it is an active-high latch-enable pulse during the address phase. In level mode it is an active-low address-valid level that returns high at the end of every byte cycle. Cycles are stretched while READY is low, up to a configured count of wait states. The program window 2000H–3FFFH is served on-chip when the external-access pin is high. In that case no bus strobe moves and the request completes in one cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: A word access runs two byte cycles, the first at the request address carrying bits 7:0 and the second at address+1 carrying bits 15:8; a byte access runs one cycle, and a byte read returns zero in bits 15:8.
- R2: In pulse mode (cfg_adv_mode=0) `as_pin` is high for exactly one clock per byte cycle, during the address phase, with the address on `ad_out`/`ad_hi` and both `rd_n` and `wr_n` high; it is low otherwise.
- R3: In level mode (cfg_adv_mode=1) `as_pin` is low from the address phase through the data phase of each byte cycle and high at the end of every byte cycle and whenever the controller is idle.
- R4: For an external read, `rd_n` is low from the strobe phase through the data phase, and the byte on `ad_in` in the last clock of that window is what the core receives.
- R5: For every external write byte `wr_n` goes low; `ad_oe` is high during the write's data phase only (never at the falling edge of `wr_n`), and the written value reads back unchanged.
- R6: `inst` is 1 throughout every byte cycle of an external instruction fetch and 0 during external data reads, writes and while idle.
- R7: With `ext_access`=1 a request to 2000H–3FFFH completes one clock after it is accepted with `rsp_int`=1 and no movement of `as_pin`, `rd_n`, `wr_n` or `inst`; with `ext_access`=0 the same address goes to the bus.
- R8: Addresses outside 2000H–3FFFH always go to the external bus regardless of `ext_access`.
- R9: `rd_n`/`wr_n` stay low for 2 + min(D, W) clocks, where D is the number of strobe-phase-onward clocks READY stays low and W is `cfg_wait_max` (0–3); when W is reached the cycle ends even with READY low.
- R10: READY has no effect while no external cycle is in progress: holding it low while idle or during an on-chip access changes neither timing nor results.
- R11: After reset the controller is idle: `rsp_busy`, `rsp_done`, `inst` and `ad_oe` are 0 and `rd_n`, `wr_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, accepted when not busy |
| req_we | input | 1 | 1 = write |
| req_word | input | 1 | 1 = 16-bit access |
| req_fetch | input | 1 | 1 = instruction fetch (reads only) |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_int | output | 1 | Completion was served on-chip |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| cfg_adv_mode | input | 1 | 0 = latch pulse, 1 = address-valid level |
| cfg_wait_max | input | 2 | Maximum inserted wait states |
| ext_access | input | 1 | 1 = window served on-chip |
| ready | input | 1 | External cycle ready |
| as_pin | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inst | output | 1 | Instruction-fetch flag |
| ad_hi | output | 8 | Address bits 15:8 |
| ad_out | output | 8 | Multiplexed address/write data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 8 | Read data from bus |

## Verification
The hardest case to reach is a wait-state cap that cuts a cycle short while READY is still low. The wait count must stop exactly at the configured limit and never include the strobe phase. The bench's bus model keeps READY low for a programmable number of strobe clocks. Sweeps pair delays below, equal to and above each limit, including limit zero with READY low. On-chip routing is checked with READY forced low, to show that READY is ignored when no bus cycle runs.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int WSW = 2,
  parameter logic [AW-1:0] WIN_LO = 'h2000,
  parameter logic [AW-1:0] WIN_HI = 'h3FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          req_word,
  input  logic          req_fetch,
  input  logic [AW-1:0] req_addr,
  input  logic [2*BW-1:0] req_wdata,
  output logic          rsp_busy,
  output logic          rsp_done,
  output logic          rsp_int,
  output logic [2*BW-1:0] rsp_rdata,
  input  logic          cfg_adv_mode,
  input  logic [WSW-1:0] cfg_wait_max,
  input  logic          ext_access,
  input  logic          ready,
  output logic          as_pin,
  output logic          rd_n,
  output logic          wr_n,
  output logic          inst,
  output logic [AW-BW-1:0] ad_hi,
  output logic [BW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [BW-1:0] ad_in
);
  localparam int DW = 2 * BW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STRB, S_WAIT, S_DATA, S_END, S_INT} st_t;

  st_t st;
  logic we_q, fetch_q, word_q, hi_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [WSW-1:0] wcnt;

  wire in_win   = (req_addr >= WIN_LO) && (req_addr <= WIN_HI);
  wire on_bus   = st inside {S_ADDR, S_STRB, S_WAIT, S_DATA, S_END};
  wire strobing = st inside {S_STRB, S_WAIT, S_DATA};
  wire adv_low  = st inside {S_ADDR, S_STRB, S_WAIT, S_DATA};
  wire more     = word_q && !hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      word_q  <= 1'b0;
      hi_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          we_q    <= req_we;
          fetch_q <= req_fetch && !req_we;
          word_q  <= req_word;
          hi_q    <= 1'b0;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          rdata_q <= '0;
          st      <= (in_win && ext_access) ? S_INT : S_ADDR;
        end
        S_INT:  st <= S_IDLE;
        S_ADDR: st <= S_STRB;
        S_STRB: begin
          wcnt <= WSW'(1);
          st   <= (ready || cfg_wait_max == '0) ? S_DATA : S_WAIT;
        end
        S_WAIT: begin
          if (ready || wcnt == cfg_wait_max) st <= S_DATA;
          else wcnt <= wcnt + 1'b1;
        end
        S_DATA: begin
          if (!we_q) begin
            if (hi_q) rdata_q[DW-1:BW] <= ad_in;
            else rdata_q[BW-1:0] <= ad_in;
          end
          st <= S_END;
        end
        S_END: begin
          if (more) begin
            hi_q   <= 1'b1;
            addr_q <= addr_q + 1'b1;
            st     <= S_ADDR;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rsp_busy  = st != S_IDLE;
  assign rsp_int   = st == S_INT;
  assign rsp_done  = rsp_int || (st == S_END && !more);
  assign rsp_rdata = rdata_q;

  assign as_pin = cfg_adv_mode ? !adv_low : (st == S_ADDR);
  assign rd_n   = !(strobing && !we_q);
  assign wr_n   = !(strobing && we_q);
  assign inst   = on_bus && fetch_q;
  assign ad_oe  = (st == S_ADDR) || (we_q && st == S_DATA);
  assign ad_hi  = addr_q[AW-1:BW];
  assign ad_out = (st == S_ADDR) ? addr_q[BW-1:0]
                : (hi_q ? wdata_q[DW-1:BW] : wdata_q[BW-1:0]);

  // R2
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv_mode && as_pin) |-> (rd_n && wr_n && ad_oe));
  // R3
  adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_adv_mode && !rsp_busy) |-> as_pin);
  // R5
  wdata_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> !ad_oe);
  // R6
  inst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable(inst));
  // R7
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_int |-> (rd_n && wr_n && !inst && rsp_done));
  // R9
  wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (wcnt <= cfg_wait_max && wcnt != '0));
  // R4
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req = 0, req_we = 0, req_word = 0, req_fetch = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic rsp_busy, rsp_done, rsp_int;
  logic [15:0] rsp_rdata;
  logic cfg_adv_mode = 0;
  logic [1:0] cfg_wait_max = 0;
  logic ext_access = 0;
  logic ready;
  logic as_pin, rd_n, wr_n, inst, ad_oe;
  logic [7:0] ad_hi, ad_out, ad_in;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_word(req_word),
    .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_busy(rsp_busy), .rsp_done(rsp_done), .rsp_int(rsp_int), .rsp_rdata(rsp_rdata),
    .cfg_adv_mode(cfg_adv_mode), .cfg_wait_max(cfg_wait_max), .ext_access(ext_access),
    .ready(ready), .as_pin(as_pin), .rd_n(rd_n), .wr_n(wr_n), .inst(inst),
    .ad_hi(ad_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // external memory model (4 KB, aliased over the address space)
  logic [7:0] mem [0:4095];
  logic [7:0] shadow [0:4095];
  logic [15:0] lat = 0;
  int lowcnt = 0;
  int dly = 0;
  bit force_nr = 0;
  assign ready = force_nr ? 1'b0 : (lowcnt > dly);
  assign ad_in = !rd_n ? mem[lat[11:0]] : 8'h00;

  // scoreboard queues
  logic [15:0] q_addr[$];
  bit          q_fetch[$];
  int          q_len[$];
  logic [15:0] q_rdata[$];
  bit          q_int[$];
  int          q_nb[$];

  bit run = 0, prev_low = 0;
  int pcnt = 0, nb_seen = 0;

  always @(negedge clk) if (rst_n && run) begin
    bit low;
    int len;
    low = !rd_n || !wr_n;
    if ((!cfg_adv_mode && as_pin) || (cfg_adv_mode && !as_pin && ad_oe && !low))
      lat = {ad_hi, ad_out};
    if (!cfg_adv_mode && as_pin) pcnt++;
    if (low) begin
      lowcnt++;
      if (!wr_n && ad_oe) mem[lat[11:0]] = ad_out;
      if (!cfg_adv_mode && as_pin) chk(0, "R2 strobe during rd/wr", 1, 0);
      if (cfg_adv_mode && as_pin) chk(0, "R3 adv high during rd/wr", 1, 0);
      if (q_fetch.size() > 0 && inst != q_fetch[0]) chk(0, "R6 inst level", inst, q_fetch[0]);
    end
    if (prev_low && !low) begin
      len = lowcnt;
      lowcnt = 0;
      if (q_addr.size() == 0) chk(0, "R1 unexpected byte cycle", 1, 0);
      else begin
        chk(lat == q_addr[0], "R1 byte address", lat, q_addr[0]);
        chk(len == q_len[0], "R9 strobe length", len, q_len[0]);
        void'(q_addr.pop_front()); void'(q_fetch.pop_front()); void'(q_len.pop_front());
      end
      if (!cfg_adv_mode) chk(pcnt == 1, "R2 pulse count", pcnt, 1);
      else chk(as_pin == 1'b1, "R3 adv return high", as_pin, 1);
      pcnt = 0;
      nb_seen++;
    end
    if (rsp_done) begin
      if (q_rdata.size() == 0) chk(0, "R1 unexpected done", 1, 0);
      else begin
        chk(rsp_rdata == q_rdata[0], "R4 read data", rsp_rdata, q_rdata[0]);
        chk(rsp_int == q_int[0], "R7 route", rsp_int, q_int[0]);
        chk(nb_seen == q_nb[0], "R8 byte cycles", nb_seen, q_nb[0]);
        void'(q_rdata.pop_front()); void'(q_int.pop_front()); void'(q_nb.pop_front());
      end
      nb_seen = 0;
      pcnt = 0;
    end
    if (!rsp_busy && inst) chk(0, "R6 inst while idle", 1, 0);
    prev_low = low;
  end

  function automatic int exp_len();
    int w;
    w = (dly < int'(cfg_wait_max)) ? dly : int'(cfg_wait_max);
    return 2 + w;
  endfunction

  task automatic access(input bit we, input bit word, input bit fetch,
                        input logic [15:0] a, input logic [15:0] wd);
    bit onchip;
    int n, nb;
    logic [15:0] exp_rd;
    onchip = ext_access && a >= 16'h2000 && a <= 16'h3FFF;
    nb = onchip ? 0 : (word ? 2 : 1);
    exp_rd = 16'h0000;
    if (!onchip) begin
      for (int i = 0; i < nb; i++) begin
        logic [15:0] ba;
        ba = a + 16'(i);
        q_addr.push_back(ba);
        q_fetch.push_back(fetch && !we);
        q_len.push_back(exp_len());
        if (we) shadow[ba[11:0]] = (i == 0) ? wd[7:0] : wd[15:8];
        else if (i == 0) exp_rd[7:0] = shadow[ba[11:0]];
        else exp_rd[15:8] = shadow[ba[11:0]];
      end
    end
    q_rdata.push_back(exp_rd);
    q_int.push_back(onchip);
    q_nb.push_back(nb);
    req_we = we; req_word = word; req_fetch = fetch; req_addr = a; req_wdata = wd;
    req = 1;
    @(negedge clk);
    req = 0;
    n = 1;
    while (!rsp_done) begin @(negedge clk); n++; end
    if (onchip) chk(n == 1, "R7 on-chip latency", n, 1);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i * 37 + 11);
      shadow[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!rsp_busy && !rsp_done && !inst && !ad_oe, "R11 idle outputs", {rsp_busy, rsp_done, inst, ad_oe}, 0);
    chk(rd_n && wr_n && !as_pin, "R11 strobes", {rd_n, wr_n, as_pin}, 3'b110);
    rst_n = 1;
    @(negedge clk);
    run = 1;

    for (int m = 0; m < 2; m++) begin
      cfg_adv_mode = m[0];
      cfg_wait_max = 0; dly = 0;
      access(0, 0, 1, 16'h0123, 0);        // R6 byte fetch, R2/R3
      access(0, 1, 0, 16'h0456, 0);        // R1 word data read
      access(0, 1, 1, 16'h0A10, 0);        // R6 word fetch
      access(1, 1, 0, 16'h0800, 16'hBEEF); // R5 word write
      access(0, 1, 0, 16'h0800, 0);        // R5 read back
      access(0, 0, 0, 16'h0801, 0);        // R1 high byte at addr+1
      access(1, 0, 0, 16'h0900, 16'h7733); // R5 byte write
      access(0, 1, 0, 16'h0900, 0);
    end

    // R9 wait-state sweep
    cfg_adv_mode = 0;
    for (int w = 0; w < 4; w++) begin
      for (int d = 0; d < 6; d++) begin
        cfg_wait_max = 2'(w); dly = d;
        access(0, 1, d[0], 16'h0300 + 16'(d), 0);
        access(1, 0, 0, 16'h0500 + 16'(w), 16'h00A5 + 16'(d));
      end
    end
    cfg_adv_mode = 1; cfg_wait_max = 3; dly = 2;
    access(0, 1, 0, 16'h0310, 0);

    // R7 / R8 / R10 routing
    cfg_wait_max = 0; dly = 0;
    ext_access = 1; force_nr = 1;
    access(0, 1, 1, 16'h2100, 0);          // R7 on-chip, READY low ignored (R10)
    access(1, 1, 0, 16'h3FFF, 16'h1234);   // R7 upper window edge
    access(0, 0, 0, 16'h2000, 0);          // R7 lower window edge
    repeat (5) @(negedge clk);             // R10 READY low while idle
    force_nr = 0;
    access(0, 0, 0, 16'h4000, 0);          // R8 above window
    access(0, 1, 0, 16'h1FFE, 0);          // R8 below window
    ext_access = 0;
    access(0, 1, 1, 16'h2100, 0);          // R7 EA low goes external
    access(1, 0, 0, 16'h3FFF, 16'h0042);
    access(0, 0, 0, 16'h3FFF, 0);

    chk(q_addr.size() == 0 && q_rdata.size() == 0, "R1 scoreboard drained", q_addr.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule